// File: doc/BRIEF.md
# Harmonic-Cancelling Direct Digital Synthesizer

This block is a direct digital synthesizer whose sine output can have two chosen harmonic spurs pre-distorted away. A 48-bit phase accumulator advances by a tuning word on every clock. The top bits of the accumulator, plus a main phase offset, address a quarter-wave sine table. Two cancellation channels run beside the main path. Each one multiplies the main phase by its own harmonic number and adds a 9-bit offset. It then looks up a sine at that phase, scales it by an 8-bit magnitude and can double it with a gain bit. When cancellation is enabled, the channel values are added to the main sample. The sum is halved for headroom and clamped to a signed 14-bit word for a DAC.

All settings are written on parallel ports and copied into shadow registers by a one-cycle update strobe. Software can therefore stage a complete new setting without glitches. The main path and both channel paths have the same pipeline depth, so a cancellation tone stays phase-locked to the main tone it is meant to cancel.

Top module: `dds_spur_top`

## Requirements
- R1: On every clock the 48-bit accumulator adds the shadowed tuning word. The main phase is accumulator bits [47:36] plus the 12-bit main offset, modulo 4096.
- R2: A 12-bit phase converts to amplitude as follows. Quadrant is phase[11:10] and index i is phase[9:0]. The table holds T[i] = round(8191·sin(π/2·(i+0.5)/1024)). Quadrant 0 gives T[i], quadrant 1 gives T[1023−i], quadrant 2 gives −T[i] and quadrant 3 gives −T[1023−i].
- R3: With cancellation disabled, the output equals the main sample and all channel settings have no effect.
- R4: A channel phase is (main phase × harmonic) mod 4096 plus the 9-bit offset shifted left by 3, modulo 4096.
- R5: A channel value is floor(sample × magnitude / 256). When the channel's gain bit is set, that value is doubled.
- R6: A channel whose harmonic number is 0 or 1 contributes zero. Only harmonics 2 to 15 are valid.
- R7: With cancellation enabled, the output is floor((main + ch1 + ch2)/2), saturated to the range −8192..8191.
- R8: Changes on the setting ports have no effect until the update strobe is high at a clock edge.
- R9: A setting captured at strobe edge E first shows at the output after the fourth rising edge that follows E. The main path, the channel paths and the enable all share this latency.
- R10: Reset clears the accumulator, all shadow settings and the output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| upd | input | 1 | Update strobe; copies all setting ports into shadow registers |
| ftw | input | 48 | Frequency tuning word |
| main_off | input | 12 | Main phase offset |
| canc_en | input | 1 | Cancellation enable |
| ch_harm | input | 8 | Harmonic numbers, channel 1 in bits [3:0], channel 2 in bits [7:4] |
| ch_off | input | 18 | 9-bit phase offsets, channel 1 in bits [8:0] |
| ch_mag | input | 16 | 8-bit magnitudes, channel 1 in bits [7:0] |
| ch_gain | input | 2 | Doubling gain bits, channel 1 in bit 0 |
| dout | output | 14 | Signed two's-complement DAC word |

## Verification
Some properties are checked on every cycle. These are the accumulator step, the sign of the table output in each half cycle, and the even LSB of a doubled channel. They also cover the silence of an out-of-range harmonic, bypass when cancellation is disabled, and shadow registers that hold without a strobe. The exact sine values, the harmonic phase wrap, the floor rounding of scaling and headroom, and saturation at both rails are shown only by the bench's vectors. So are the four-edge settings latency and the quadrant-per-clock stepping of a running accumulator.

// File: rtl/dds_spur_pkg.sv
package dds_spur_pkg;
  localparam int ACC_W_D  = 48;
  localparam int PH_W_D   = 12;
  localparam int AMP_W_D  = 14;
  localparam int HARM_W_D = 4;
  localparam int OFF_W_D  = 9;
  localparam int MAG_W_D  = 8;
  localparam int NCH_D    = 2;
  localparam real HALF_PI = 1.5707963267948966;
endpackage

// File: rtl/dds_sine_rom.sv
module dds_sine_rom import dds_spur_pkg::*; #(
  parameter int PH_W  = PH_W_D,
  parameter int AMP_W = AMP_W_D
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [PH_W-1:0]         ph,
  output logic signed [AMP_W-1:0] samp
);
  localparam int IDX_W = PH_W - 2;
  localparam int DEPTH = 1 << IDX_W;
  localparam real PEAK = real'((1 << (AMP_W - 1)) - 1);

  logic [AMP_W-2:0] quarter [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_tbl
    localparam real ANG = HALF_PI * (real'(i) + 0.5) / real'(DEPTH);
    assign quarter[i] = (AMP_W-1)'($rtoi(PEAK * $sin(ANG) + 0.5));
  end

  logic [1:0]       quad;
  logic [IDX_W-1:0] idx, addr;
  logic [AMP_W-2:0] mag;

  always_comb begin
    quad = ph[PH_W-1 -: 2];
    idx  = ph[IDX_W-1:0];
    addr = quad[0] ? ~idx : idx;
    mag  = quarter[addr];
  end

  always_ff @(posedge clk) begin
    if (rst) samp <= '0;
    else     samp <= quad[1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
  end

  assert_neg_half_R2: assert property (@(posedge clk) disable iff (rst)
    ph[PH_W-1] |=> samp < 0);
  assert_pos_half_R2: assert property (@(posedge clk) disable iff (rst)
    !ph[PH_W-1] |=> samp > 0);
endmodule

// File: rtl/dds_cancel_chan.sv
module dds_cancel_chan import dds_spur_pkg::*; #(
  parameter int PH_W   = PH_W_D,
  parameter int AMP_W  = AMP_W_D,
  parameter int HARM_W = HARM_W_D,
  parameter int OFF_W  = OFF_W_D,
  parameter int MAG_W  = MAG_W_D
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [PH_W-1:0]           ph_main,
  input  logic [HARM_W-1:0]         harm,
  input  logic [OFF_W-1:0]          off,
  input  logic [MAG_W-1:0]          mag,
  input  logic                      gain,
  output logic signed [AMP_W:0]     scaled
);
  localparam int SC_W   = AMP_W + 1;
  localparam int PROD_W = AMP_W + MAG_W + 1;

  logic [PH_W-1:0]         ph_c;
  logic [MAG_W-1:0]        mag_p1, mag_p2;
  logic                    g_p1, g_p2, hok_p1, hok_p2;
  logic signed [AMP_W-1:0] samp;
  logic signed [PROD_W-1:0] prod;
  logic signed [SC_W-1:0]  base;

  // stage 1: harmonic phase
  always_ff @(posedge clk) begin
    if (rst) begin
      ph_c <= '0; mag_p1 <= '0; g_p1 <= 1'b0; hok_p1 <= 1'b0;
    end else begin
      ph_c   <= PH_W'(ph_main * {{(PH_W-HARM_W){1'b0}}, harm})
              + {off, {(PH_W-OFF_W){1'b0}}};
      mag_p1 <= mag;
      g_p1   <= gain;
      hok_p1 <= harm > HARM_W'(1);
    end
  end

  // stage 2: table lookup
  dds_sine_rom #(.PH_W(PH_W), .AMP_W(AMP_W)) u_rom (
    .clk(clk), .rst(rst), .ph(ph_c), .samp(samp));

  always_ff @(posedge clk) begin
    if (rst) begin
      mag_p2 <= '0; g_p2 <= 1'b0; hok_p2 <= 1'b0;
    end else begin
      mag_p2 <= mag_p1; g_p2 <= g_p1; hok_p2 <= hok_p1;
    end
  end

  // stage 3: magnitude and gain
  always_comb begin
    prod = samp * $signed({1'b0, mag_p2});
    base = SC_W'(prod >>> MAG_W);
  end

  always_ff @(posedge clk) begin
    if (rst)          scaled <= '0;
    else if (!hok_p2) scaled <= '0;
    else              scaled <= g_p2 ? (base <<< 1) : base;
  end

  assert_low_harm_silent_R6: assert property (@(posedge clk) disable iff (rst)
    !hok_p2 |=> scaled == '0);
  assert_gain_even_R5: assert property (@(posedge clk) disable iff (rst)
    g_p2 |=> !scaled[0]);
endmodule

// File: rtl/dds_spur_top.sv
module dds_spur_top import dds_spur_pkg::*; #(
  parameter int ACC_W  = ACC_W_D,
  parameter int PH_W   = PH_W_D,
  parameter int AMP_W  = AMP_W_D,
  parameter int HARM_W = HARM_W_D,
  parameter int OFF_W  = OFF_W_D,
  parameter int MAG_W  = MAG_W_D,
  parameter int NCH    = NCH_D
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    upd,
  input  logic [ACC_W-1:0]        ftw,
  input  logic [PH_W-1:0]         main_off,
  input  logic                    canc_en,
  input  logic [NCH*HARM_W-1:0]   ch_harm,
  input  logic [NCH*OFF_W-1:0]    ch_off,
  input  logic [NCH*MAG_W-1:0]    ch_mag,
  input  logic [NCH-1:0]          ch_gain,
  output logic signed [AMP_W-1:0] dout
);
  localparam int SC_W  = AMP_W + 1;
  localparam int SUM_W = SC_W + $clog2(NCH + 1) + 1;
  localparam logic signed [SUM_W-1:0] HI = SUM_W'((1 << (AMP_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] LO = -HI - 1;

  // shadow settings
  logic [ACC_W-1:0]      sh_ftw;
  logic [PH_W-1:0]       sh_moff;
  logic                  sh_en;
  logic [NCH*HARM_W-1:0] sh_harm;
  logic [NCH*OFF_W-1:0]  sh_off;
  logic [NCH*MAG_W-1:0]  sh_mag;
  logic [NCH-1:0]        sh_gain;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_ftw <= '0; sh_moff <= '0; sh_en <= 1'b0;
      sh_harm <= '0; sh_off <= '0; sh_mag <= '0; sh_gain <= '0;
    end else if (upd) begin
      sh_ftw <= ftw; sh_moff <= main_off; sh_en <= canc_en;
      sh_harm <= ch_harm; sh_off <= ch_off; sh_mag <= ch_mag; sh_gain <= ch_gain;
    end
  end

  logic [ACC_W-1:0] acc;
  logic [PH_W-1:0]  ph_now, main_ph;
  logic signed [AMP_W-1:0] main_s, main_d;
  logic en_p1, en_p2, en_p3;

  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else     acc <= acc + sh_ftw;
  end

  assign ph_now = acc[ACC_W-1 -: PH_W] + sh_moff;

  always_ff @(posedge clk) begin
    if (rst) begin
      main_ph <= '0; main_d <= '0;
      en_p1 <= 1'b0; en_p2 <= 1'b0; en_p3 <= 1'b0;
    end else begin
      main_ph <= ph_now;
      main_d  <= main_s;
      en_p1 <= sh_en; en_p2 <= en_p1; en_p3 <= en_p2;
    end
  end

  dds_sine_rom #(.PH_W(PH_W), .AMP_W(AMP_W)) u_main_rom (
    .clk(clk), .rst(rst), .ph(main_ph), .samp(main_s));

  logic signed [SC_W-1:0] ch_val [NCH];

  for (genvar k = 0; k < NCH; k++) begin : g_chan
    dds_cancel_chan #(.PH_W(PH_W), .AMP_W(AMP_W), .HARM_W(HARM_W),
                      .OFF_W(OFF_W), .MAG_W(MAG_W)) u_chan (
      .clk(clk), .rst(rst), .ph_main(ph_now),
      .harm(sh_harm[k*HARM_W +: HARM_W]),
      .off(sh_off[k*OFF_W +: OFF_W]),
      .mag(sh_mag[k*MAG_W +: MAG_W]),
      .gain(sh_gain[k]),
      .scaled(ch_val[k]));
  end

  logic signed [SUM_W-1:0] sum, half;
  logic all_nonneg;

  always_comb begin
    sum = SUM_W'(main_d);
    all_nonneg = main_d >= 0;
    for (int k = 0; k < NCH; k++) begin
      sum = sum + SUM_W'(ch_val[k]);
      all_nonneg = all_nonneg && (ch_val[k] >= 0);
    end
    half = sum >>> 1;
  end

  always_ff @(posedge clk) begin
    if (rst)         dout <= '0;
    else if (!en_p3) dout <= main_d;
    else if (half > HI) dout <= AMP_W'(HI);
    else if (half < LO) dout <= AMP_W'(LO);
    else             dout <= AMP_W'(half);
  end

  assert_acc_step_R1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> acc == $past(acc) + $past(sh_ftw));
  assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(sh_ftw) && $stable(sh_en) && $stable(sh_harm));
  assert_bypass_R3: assert property (@(posedge clk) disable iff (rst)
    !en_p3 |=> dout == $past(main_d));
  assert_sign_kept_R7: assert property (@(posedge clk) disable iff (rst)
    en_p3 && all_nonneg |=> dout >= 0);
endmodule

// File: tb/dds_spur_top_test.sv
module dds_spur_top_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic upd = 1'b0;
  logic [47:0] ftw = '0;
  logic [11:0] main_off = '0;
  logic canc_en = 1'b0;
  logic [7:0]  ch_harm = '0;
  logic [17:0] ch_off = '0;
  logic [15:0] ch_mag = '0;
  logic [1:0]  ch_gain = '0;
  logic signed [13:0] dout;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dds_spur_top uut (.clk(clk), .rst(rst), .upd(upd), .ftw(ftw), .main_off(main_off),
    .canc_en(canc_en), .ch_harm(ch_harm), .ch_off(ch_off), .ch_mag(ch_mag),
    .ch_gain(ch_gain), .dout(dout));

  typedef struct packed {
    logic [11:0] moff; logic en;
    logic [3:0] h1; logic [8:0] o1; logic [7:0] m1; logic g1;
    logic [3:0] h2; logic [8:0] o2; logic [7:0] m2; logic g2;
    logic signed [15:0] exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{12'd0,    1'b0, 4'd3,  9'd128, 8'd255, 1'b1, 4'd0, 9'd0,   8'd0,   1'b0, 16'sd6},     // R3 bypass
    '{12'd1024, 1'b0, 4'd0,  9'd0,   8'd0,   1'b0, 4'd0, 9'd0,   8'd0,   1'b0, 16'sd8191},  // R2 q1
    '{12'd2048, 1'b0, 4'd0,  9'd0,   8'd0,   1'b0, 4'd0, 9'd0,   8'd0,   1'b0, -16'sd6},    // R2 q2
    '{12'd0,    1'b1, 4'd2,  9'd128, 8'd128, 1'b0, 4'd0, 9'd0,   8'd0,   1'b0, 16'sd2050},  // R4 R5 R7
    '{12'd0,    1'b1, 4'd2,  9'd128, 8'd128, 1'b1, 4'd0, 9'd0,   8'd0,   1'b0, 16'sd4098},  // R5 gain
    '{12'd1024, 1'b1, 4'd2,  9'd384, 8'd255, 1'b1, 4'd3, 9'd256, 8'd255, 1'b1, 16'sd8191},  // R7 top rail
    '{12'd3072, 1'b1, 4'd2,  9'd128, 8'd255, 1'b1, 4'd3, 9'd256, 8'd255, 1'b1, -16'sd8192}, // R7 bottom rail
    '{12'd0,    1'b1, 4'd1,  9'd128, 8'd255, 1'b1, 4'd0, 9'd0,   8'd0,   1'b0, 16'sd3},     // R6
    '{12'd1024, 1'b1, 4'd2,  9'd128, 8'd128, 1'b0, 4'd5, 9'd0,   8'd64,  1'b0, 16'sd3071},  // R4 wrap
    '{12'd0,    1'b1, 4'd15, 9'd256, 8'd255, 1'b0, 4'd0, 9'd0,   8'd0,   1'b0, 16'sd0}      // R5 floor
  };

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic load(input vec_t v);
    main_off = v.moff; canc_en = v.en;
    ch_harm = {v.h2, v.h1}; ch_off = {v.o2, v.o1};
    ch_mag = {v.m2, v.m1}; ch_gain = {v.g2, v.g1};
  endtask

  task automatic strobe();
    upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R9: got hang expected completion (watchdog)");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v[5];
    repeat (3) @(negedge clk);
    chk("R10 reset output", int'(dout), 0);
    rst = 1'b0;
    repeat (8) @(negedge clk);
    chk("R10 reset state gives phase zero", int'(dout), 6);

    for (int n = 0; n < NV; n++) begin
      load(VECS[n]);
      strobe();
      repeat (7) @(negedge clk);
      chk($sformatf("R7 vector %0d", n), int'(dout), int'(VECS[n].exp));
    end

    // R8: no strobe, no change
    main_off = 12'd1024; canc_en = 1'b0;
    repeat (8) @(negedge clk);
    chk("R8 hold without strobe", int'(dout), 0);

    // R9: latency of four edges after the strobe edge
    strobe();
    @(negedge clk); chk("R9 old value edge 1", int'(dout), 0);
    @(negedge clk); chk("R9 old value edge 2", int'(dout), 0);
    @(negedge clk); chk("R9 old value edge 3", int'(dout), 0);
    @(negedge clk); chk("R9 new value edge 4", int'(dout), 8191);

    // R1: quarter-turn per clock
    ftw = 48'h4000_0000_0000; main_off = '0; canc_en = 1'b0;
    strobe();
    repeat (7) @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      v[i] = int'(dout);
      @(negedge clk);
    end
    for (int i = 0; i < 3; i++) chk("R1 half-turn negates", v[i+2], -v[i]);
    for (int i = 0; i < 4; i++) begin
      chk("R1 quadrant sample", (v[i] == 6 || v[i] == -6 || v[i] == 8191 || v[i] == -8191) ? 1 : 0, 1);
      chk("R1 advances each clock", (v[i+1] != v[i]) ? 1 : 0, 1);
    end

    // R10: reset clears running accumulator
    rst = 1'b1;
    @(negedge clk);
    chk("R10 output in reset", int'(dout), 0);
    rst = 1'b0;
    ftw = '0;
    repeat (8) @(negedge clk);
    chk("R10 accumulator and shadows cleared", int'(dout), 6);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule